// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block is a serial-bus slave for a small bank of 8-bit configuration registers. A host reaches the bank over the two-wire SMBus interface through four transaction shapes: byte write, byte read, block write and block read. The block samples the raw SCL and SDA lines and returns one open-drain enable for SDA. A high enable means the pad pulls SDA low. The current value of every register is presented to the surrounding logic as one flat vector. Each accepted write also produces a one-cycle strobe carrying the register index and the data.

Both lines pass through a two-flop synchroniser and a two-sample agreement filter before any decoding. START and STOP are recognised as SDA edges while the filtered SCL is high. After the device address and a write bit, the host sends a command byte. Bit 7 of the command selects the mode: 1 is single-byte, 0 is block. The low IW bits give the starting register index. A repeated START followed by the address with the read bit turns the transaction into a read from that index.

A block read returns the register count first, then the registers in index order. A block write expects a count byte first and then exactly that many data bytes. One register is fixed to an identifier value and cannot be written. No stream data leaves the block, so there is no valid/ready pair. The write strobe is a plain pulse that internal logic must accept in the same cycle, with no back-pressure.

Top module: `smb_reg_slave`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal DEV_ADDR (default 7'h2C). For any other address, SDA is not driven for the rest of the transaction, and later bytes neither get an acknowledge nor change a register.
- R2: In single-byte mode (command bit 7 = 1), one data byte is acknowledged and written to the indexed register. A second data byte in the same transaction is not acknowledged and is not written.
- R3: In block mode (command bit 7 = 0), the first byte after the command is a count N. The next N data bytes are acknowledged and written. Byte N+1 is not acknowledged and changes nothing.
- R4: The register index advances by one after every data byte written or read. It wraps from NREG-1 to 0, where NREG = 2**IW (default 8).
- R5: A block read returns the byte NREG first. It then returns the registers starting at the command index, for as long as the host acknowledges.
- R6: A single-byte read returns the register selected by the command index.
- R7: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing until the next START.
- R8: Register ID_IDX (default 7) always reads ID_VAL (default 8'h3A). A write to it is acknowledged but changes nothing and raises no strobe.
- R9: Every accepted write to a writable register raises wr_stb for exactly one cycle, with wr_idx and wr_data set to that index and byte. In the same cycle, the register image already holds the new byte.
- R10: During and after reset, sda_oe is 0, every writable register is 0, and the identifier register reads ID_VAL.
- R11: A STOP ends any transaction at once and keeps the bytes already accepted. A repeated START between the command byte and the read address is accepted.
- R12: sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the bus |
| sda_oe | output | 1 | 1 = pull SDA low (open drain) |
| cfg_flat | output | NREG*8 | All register values; register k occupies bits [8k+7:8k] |
| wr_stb | output | 1 | One-cycle pulse per accepted write to a writable register |
| wr_idx | output | IW | Index of the register just written |
| wr_data | output | 8 | Byte just written |

## Verification
The assertions assume the host keeps SDA steady while SCL is high, except at START and STOP. They also assume each SCL phase lasts longer than the six-cycle input filter latency. If either fails, the filtered lines can show a false START, and the check that sda_oe moves only while SCL is low no longer holds. The bench keeps both half-periods of SCL at 16 clocks and changes SDA only 8 clocks after SCL has fallen. It never leaves the host and the slave both driving conflicting levels during a data bit.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WCNT,
    ST_WDATA,
    ST_RD,
    ST_SKIP
  } smb_st_e;
endpackage

// File: rtl/smb_filter.sv
module smb_filter #(
  parameter int   SYNC    = 2,
  parameter int   FILT    = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [SYNC-1:0] sy;
  logic [FILT-1:0] hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy   <= {SYNC{RST_VAL}};
      hist <= {FILT{RST_VAL}};
      dout <= RST_VAL;
    end else begin
      sy   <= {sy[SYNC-2:0], din};
      hist <= {hist[FILT-2:0], sy[SYNC-1]};
      if (&hist)       dout <= 1'b1;
      else if (~|hist) dout <= 1'b0;
    end
  end
endmodule

// File: rtl/smb_proto.sv
module smb_proto
  import smb_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         IW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_f,
  input  logic          sda_f,
  input  logic [7:0]    reg_rdata,
  output logic [IW-1:0] reg_idx,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic [7:0]    wr_data
);
  localparam int         NREG     = 1 << IW;
  localparam logic [7:0] CNT_BYTE = 8'(NREG);

  smb_st_e     st;
  logic        scl_d, sda_d, in_ack, mack, blk, cnt_first;
  logic [3:0]  bc;
  logic [7:0]  sh, tx, left;
  logic        scl_rise, scl_fall, start_c, stop_c;

  assign scl_rise = scl_f & ~scl_d;
  assign scl_fall = ~scl_f & scl_d;
  assign start_c  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_c   = scl_f & scl_d & ~sda_d & sda_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;   scl_d <= 1'b1; sda_d <= 1'b1;
      in_ack <= 1'b0;  mack <= 1'b0;  blk <= 1'b0; cnt_first <= 1'b0;
      bc <= '0; sh <= '0; tx <= '0; left <= '0;
      reg_idx <= '0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
      wr_en <= 1'b0;
      if (start_c) begin
        st <= ST_ADDR; bc <= '0; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (stop_c) begin
        st <= ST_IDLE; in_ack <= 1'b0; sda_oe <= 1'b0;
      end else if (st != ST_IDLE && st != ST_SKIP) begin
        if (scl_rise) begin
          if (in_ack) mack <= ~sda_f;
          else begin
            bc <= bc + 4'd1;
            sh <= {sh[6:0], sda_f};
          end
        end else if (scl_fall) begin
          if (in_ack) begin
            in_ack <= 1'b0;
            bc     <= '0;
            if (st == ST_RD) begin
              if (mack) begin
                if (cnt_first) begin
                  tx <= CNT_BYTE; sda_oe <= ~CNT_BYTE[7]; cnt_first <= 1'b0;
                end else begin
                  tx <= reg_rdata; sda_oe <= ~reg_rdata[7];
                  reg_idx <= reg_idx + 1'b1;
                end
              end else begin
                st <= ST_SKIP; sda_oe <= 1'b0;
              end
            end else sda_oe <= 1'b0;
          end else if (bc == 4'd8) begin
            in_ack <= 1'b1;
            unique case (st)
              ST_ADDR: begin
                if (sh[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  if (sh[0]) begin
                    st <= ST_RD; mack <= 1'b1; cnt_first <= blk;
                  end else st <= ST_CMD;
                end else st <= ST_SKIP;
              end
              ST_CMD: begin
                sda_oe  <= 1'b1;
                blk     <= ~sh[7];
                reg_idx <= sh[IW-1:0];
                left    <= 8'd1;
                st      <= sh[7] ? ST_WDATA : ST_WCNT;
              end
              ST_WCNT: begin
                sda_oe <= 1'b1; left <= sh; st <= ST_WDATA;
              end
              ST_WDATA: begin
                if (left != 8'd0) begin
                  sda_oe  <= 1'b1;
                  left    <= left - 8'd1;
                  reg_idx <= reg_idx + 1'b1;
                  wr_en   <= 1'b1;
                  wr_idx  <= reg_idx;
                  wr_data <= sh;
                end else st <= ST_SKIP;
              end
              default: sda_oe <= 1'b0;
            endcase
          end else if (st == ST_RD && bc != 4'd0) begin
            tx     <= {tx[6:0], 1'b0};
            sda_oe <= ~tx[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/smb_regbank.sv
module smb_regbank #(
  parameter int         IW     = 3,
  parameter int         ID_IDX = 7,
  parameter logic [7:0] ID_VAL = 8'h3A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IW-1:0]         widx,
  input  logic [7:0]            wdata,
  input  logic [IW-1:0]         ridx,
  output logic [7:0]            rdata,
  output logic [(8<<IW)-1:0]    cfg_flat,
  output logic                  stb,
  output logic [IW-1:0]         stb_idx,
  output logic [7:0]            stb_data
);
  localparam int NREG = 1 << IW;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == ID_IDX) begin : g_ro
      assign cfg_flat[g*8 +: 8] = ID_VAL;
    end else begin : g_rw
      logic [7:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= '0;
        else if (wr_en && widx == IW'(g)) r <= wdata;
      end
      assign cfg_flat[g*8 +: 8] = r;
    end
  end

  assign rdata = cfg_flat[int'(ridx)*8 +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb <= 1'b0; stb_idx <= '0; stb_data <= '0;
    end else begin
      stb      <= wr_en && (widx != IW'(ID_IDX));
      stb_idx  <= widx;
      stb_data <= wdata;
    end
  end
endmodule

// File: rtl/smb_reg_slave.sv
module smb_reg_slave #(
  parameter logic [6:0] DEV_ADDR = 7'h2C,
  parameter int         IW       = 3,
  parameter int         ID_IDX   = 7,
  parameter logic [7:0] ID_VAL   = 8'h3A,
  parameter int         SYNC     = 2,
  parameter int         FILT     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  output logic [(8<<IW)-1:0]    cfg_flat,
  output logic                  wr_stb,
  output logic [IW-1:0]         wr_idx,
  output logic [7:0]            wr_data
);
  logic [1:0]    raw, filt;
  logic [7:0]    rdata;
  logic [IW-1:0] ridx, p_widx;
  logic [7:0]    p_wdata;
  logic          p_wen;

  assign raw = {scl_i, sda_i};

  for (genvar i = 0; i < 2; i++) begin : g_in
    smb_filter #(.SYNC(SYNC), .FILT(FILT), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(raw[i]), .dout(filt[i])
    );
  end

  smb_proto #(.DEV_ADDR(DEV_ADDR), .IW(IW)) u_proto (
    .clk(clk), .rst_n(rst_n), .scl_f(filt[1]), .sda_f(filt[0]),
    .reg_rdata(rdata), .reg_idx(ridx), .sda_oe(sda_oe),
    .wr_en(p_wen), .wr_idx(p_widx), .wr_data(p_wdata)
  );

  smb_regbank #(.IW(IW), .ID_IDX(ID_IDX), .ID_VAL(ID_VAL)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(p_wen), .widx(p_widx), .wdata(p_wdata),
    .ridx(ridx), .rdata(rdata), .cfg_flat(cfg_flat),
    .stb(wr_stb), .stb_idx(wr_idx), .stb_data(wr_data)
  );
endmodule

// File: rtl/smb_reg_slave_chk.sv
module smb_reg_slave_chk #(
  parameter int IW     = 3,
  parameter int ID_IDX = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               scl_i,
  input logic               sda_oe,
  input logic [(8<<IW)-1:0] cfg_flat,
  input logic               wr_stb,
  input logic [IW-1:0]      wr_idx,
  input logic [7:0]         wr_data
);
  logic [7:0] at_widx;
  assign at_widx = cfg_flat[int'(wr_idx)*8 +: 8];

  // R10: reset keeps the data line released
  a_r10_reset_quiet: assert property (@(posedge clk) !rst_n |=> !sda_oe);

  // R12: open-drain enable moves only during SCL low
  a_r12_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  // R9: strobe lasts one cycle
  a_r9_single_cycle_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R9: register image holds the strobed byte
  a_r9_strobe_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> at_widx == wr_data);

  // R8: identifier register never strobes
  a_r8_no_id_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> wr_idx != IW'(ID_IDX));
endmodule

bind smb_reg_slave smb_reg_slave_chk #(.IW(IW), .ID_IDX(ID_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_flat(cfg_flat), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
);

// File: tb/smb_reg_slave_tb.sv
module smb_reg_slave_tb;
  localparam logic [6:0] ADDR = 7'h2C;
  localparam int         Q    = 8;
  localparam int         NR   = 8;
  localparam int         IDI  = 7;
  localparam logic [7:0] IDV  = 8'h3A;

  logic clk = 0, rst_n = 0, scl_m = 1, sda_m = 1;
  wire  sda_oe;
  wire  sda_bus = sda_m & ~sda_oe;
  wire [63:0] cfg_flat;
  wire        wr_stb;
  wire [2:0]  wr_idx;
  wire [7:0]  wr_data;

  always #10 clk = ~clk;

  smb_reg_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .cfg_flat(cfg_flat), .wr_stb(wr_stb), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  int nvec = 0, nfail = 0, stb_cnt = 0, oe_hi = 0, oe_bad = 0;
  bit done = 0;
  logic [7:0] mdl [NR];
  logic [2:0] last_idx;
  logic [7:0] last_data;
  logic       oe_prev = 0;

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin stb_cnt++; last_idx = wr_idx; last_data = wr_data; end
    if (sda_oe) oe_hi++;
    if (sda_oe != oe_prev && scl_m) oe_bad++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic m_start;
    tick(Q); sda_m = 1; tick(Q); scl_m = 1; tick(2*Q); sda_m = 0; tick(2*Q); scl_m = 0;
  endtask
  task automatic m_stop;
    tick(Q); sda_m = 0; tick(Q); scl_m = 1; tick(2*Q); sda_m = 1; tick(2*Q);
  endtask
  task automatic m_wr(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0;
    end
    tick(Q); sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = !sda_bus; tick(Q); scl_m = 0;
  endtask
  task automatic m_rd(input bit give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      tick(Q); sda_m = 1; tick(Q); scl_m = 1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 0;
    end
    tick(Q); sda_m = !give_ack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0;
  endtask

  function automatic logic [63:0] image();
    logic [63:0] v;
    for (int k = 0; k < NR; k++) v[k*8 +: 8] = mdl[k];
    return v;
  endfunction

  function automatic logic [7:0] pat(input int s, input int k);
    return 8'((s*29 + k*71 + 13) & 255);
  endfunction

  task automatic wbyte(input int idx, input logic [7:0] d);
    bit a;
    m_start;
    m_wr({ADDR, 1'b0}, a); chk(a, "R1 addr ack", a, 1);
    m_wr({1'b1, 4'b0, 3'(idx)}, a); chk(a, "R2 cmd ack", a, 1);
    m_wr(d, a); chk(a, "R2 data ack", a, 1);
    m_stop;
    if (idx != IDI) mdl[idx] = d;
  endtask

  task automatic rbyte(input int idx);
    bit a; logic [7:0] b;
    m_start;
    m_wr({ADDR, 1'b0}, a);
    m_wr({1'b1, 4'b0, 3'(idx)}, a);
    m_start;
    m_wr({ADDR, 1'b1}, a); chk(a, "R11 repeated start addr ack", a, 1);
    m_rd(0, b); chk(b == mdl[idx], "R6 byte read", b, mdl[idx]);
    m_stop;
  endtask

  task automatic bwrite(input int s, input int n, input bit extra);
    bit a; int c0, expn;
    c0 = stb_cnt; expn = 0;
    m_start;
    m_wr({ADDR, 1'b0}, a);
    m_wr({1'b0, 4'b0, 3'(s)}, a); chk(a, "R3 cmd ack", a, 1);
    m_wr(8'(n), a); chk(a, "R3 count ack", a, 1);
    for (int k = 0; k < n; k++) begin
      m_wr(pat(s, k), a); chk(a, "R3 data ack", a, 1);
      if ((s + k) % NR != IDI) begin mdl[(s + k) % NR] = pat(s, k); expn++; end
    end
    if (extra) begin m_wr(8'hC3, a); chk(!a, "R3 excess byte nack", a, 0); end
    m_stop;
    chk(stb_cnt - c0 == expn, "R9 strobe count", stb_cnt - c0, expn);
    chk(cfg_flat == image(), "R4 block write image", 0, 0);
  endtask

  task automatic bread(input int s);
    bit a; logic [7:0] b;
    m_start;
    m_wr({ADDR, 1'b0}, a);
    m_wr({1'b0, 4'b0, 3'(s)}, a);
    m_start;
    m_wr({ADDR, 1'b1}, a);
    m_rd(1, b); chk(b == 8'(NR), "R5 count byte", b, NR);
    for (int k = 0; k < NR; k++) begin
      m_rd(k != NR - 1, b);
      chk(b == mdl[(s + k) % NR], "R5 R4 block read data", b, mdl[(s + k) % NR]);
    end
    m_stop;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++; nvec++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    bit a; logic [7:0] b; int c0, o0;
    for (int k = 0; k < NR; k++) mdl[k] = (k == IDI) ? IDV : 8'h00;
    tick(5);
    chk(sda_oe == 0, "R10 oe in reset", sda_oe, 0);
    rst_n = 1; tick(5);
    chk(sda_oe == 0, "R10 oe after reset", sda_oe, 0);
    chk(cfg_flat == image(), "R10 reset image", cfg_flat[7:0], 0);

    // R1: foreign address
    o0 = oe_hi;
    m_start;
    m_wr({7'h13, 1'b0}, a); chk(!a, "R1 foreign addr nack", a, 0);
    m_wr(8'h85, a); chk(!a, "R1 foreign cmd nack", a, 0);
    m_wr(8'h55, a); chk(!a, "R1 foreign data nack", a, 0);
    m_stop;
    chk(oe_hi == o0, "R1 no drive", oe_hi - o0, 0);
    chk(cfg_flat == image(), "R1 no change", 0, 0);

    // R2 R9: byte writes over every index
    for (int i = 0; i < NR; i++) begin
      c0 = stb_cnt;
      wbyte(i, 8'((i*37 + 5) & 255));
      if (i != IDI) begin
        chk(stb_cnt == c0 + 1, "R9 one strobe", stb_cnt - c0, 1);
        chk(last_idx == 3'(i) && last_data == 8'((i*37 + 5) & 255), "R9 strobe fields", last_data, (i*37 + 5) & 255);
      end else begin
        chk(stb_cnt == c0, "R8 no strobe on id", stb_cnt - c0, 0);
      end
    end
    chk(cfg_flat == image(), "R2 image after byte writes", 0, 0);
    for (int i = 0; i < NR; i++) rbyte(i);
    chk(cfg_flat[IDI*8 +: 8] == IDV, "R8 id value", cfg_flat[IDI*8 +: 8], IDV);

    // R2: second byte in single-byte mode
    m_start;
    m_wr({ADDR, 1'b0}, a);
    m_wr({1'b1, 4'b0, 3'd4}, a);
    m_wr(8'hE1, a); chk(a, "R2 first byte ack", a, 1);
    m_wr(8'h1E, a); chk(!a, "R2 second byte nack", a, 0);
    m_stop;
    mdl[4] = 8'hE1;
    chk(cfg_flat == image(), "R2 only one byte written", cfg_flat[47:40], mdl[5]);

    // R3 R4 R8: block writes from each start, count s+1, plus an excess byte
    for (int s = 0; s < NR; s++) bwrite(s, s + 1, 1);
    bwrite(5, 0, 1);

    // R5 R4: block reads from each start
    for (int s = 0; s < NR; s++) bread(s);

    // R7: after nack the slave stays off the bus
    m_start;
    m_wr({ADDR, 1'b0}, a);
    m_wr({1'b1, 4'b0, 3'd2}, a);
    m_start;
    m_wr({ADDR, 1'b1}, a);
    m_rd(0, b); chk(b == mdl[2], "R7 read before nack", b, mdl[2]);
    m_rd(0, b); chk(b == 8'hFF, "R7 released after nack", b, 8'hFF);
    m_stop;

    // R11: stop in the middle of a block write keeps accepted bytes
    c0 = stb_cnt;
    m_start;
    m_wr({ADDR, 1'b0}, a);
    m_wr({1'b0, 4'b0, 3'd1}, a);
    m_wr(8'd4, a);
    m_wr(8'h91, a); m_wr(8'h92, a);
    m_stop;
    mdl[1] = 8'h91; mdl[2] = 8'h92;
    chk(stb_cnt - c0 == 2, "R11 stop abort strobes", stb_cnt - c0, 2);
    chk(cfg_flat == image(), "R11 stop abort image", cfg_flat[31:24], mdl[3]);
    rbyte(3);

    chk(oe_bad == 0, "R12 oe moved with scl high", oe_bad, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule